// File: doc/BRIEF.md
# Interrupt-Continuable Load/Store Sequencer

This block runs the multi-cycle memory and arithmetic operations of a small processor datapath: block loads and stores over a register list, paired-word loads and stores, and an iterative unsigned divide. It also decides what each of these does when an interrupt request arrives part way through. Stack push and pop are issued to it as block stores and block loads, so they pause and resume in the same way.

A block transfer that is interrupted finishes its current memory beat and then stops. It reports the index of the next register still to move on `cont_idx`, and the surrounding core stacks that value with its status word. When the core later returns, it reissues the same descriptor with that index on `op_resume`, and the transfer picks up where it stopped. A paired-word transfer or a divide that is interrupted is simply dropped. The core reissues it from the start afterwards, so a paired load can read its first word twice.

Descriptors enter over a valid/ready handshake. `op_ready` is high only while the sequencer is idle. A descriptor is taken on a clock edge where `op_valid` and `op_ready` are both high. The memory port is a single valid/ready channel: once `mem_valid` is raised, the address, direction and write data hold until `mem_ready` completes the beat, and read data is taken in that same cycle.

Top module: `ldst_seq`

## Requirements
- R1: After reset `op_ready` is 1 and `mem_valid`, `rf_we`, `irq_ack` and `done` are 0; `op_ready` stays 0 from the cycle after a descriptor is accepted until the operation ends. Operation codes on `op_kind`: 0 block load, 1 block store, 2 paired load, 3 paired store, 4 divide.
- R2: A block transfer visits the set bits of `op_list` from lowest to highest index. The k-th beat (counting from 0) uses address `op_base + 4*k`. A load writes `mem_rdata` to that register; a store drives `mem_wdata` from `rf_rd_data` with `rf_rd_idx` set to that register. An empty list ends with `done` and makes no beats.
- R3: While `mem_valid` is 1 and `mem_ready` is 0, the address, write flag and write data stay unchanged. An interrupt cannot withdraw a beat that has started.
- R4: If `irq_req` is 1 in the cycle a block beat completes and set bits remain above it, then for exactly that cycle `irq_ack` is 1 and `cont_idx` is the next set register index (never 0). `op_ready` is 1 in the next cycle.
- R5: A block transfer whose `op_resume` is nonzero starts at the lowest set bit at or above `op_resume`, with address `op_base + 4*(set bits below op_resume)`. Registers below it are not transferred.
- R6: An interrupt that coincides with the final beat of a block transfer is not accepted; the transfer ends with `done`.
- R7: A paired transfer makes two beats, at `op_base` with register `op_dest` and at `op_base+4` with register `(op_dest+1) mod 16`.
- R8: An interrupt in the cycle the first paired beat completes cancels the operation: `irq_ack` with `cont_idx` 0, and no second beat. A reissue starts again from the first word.
- R9: A divide with a nonzero divisor runs 32 restoring iterations. It writes the quotient to `op_dest` and then the remainder to `op_dest+1`, with `done` 34 cycles after acceptance.
- R10: An interrupt during any divide iteration cancels it: `irq_ack` with `cont_idx` 0 and no register write. A reissue gives the full result.
- R11: A divide by zero skips the iterations and writes quotient 0 and remainder equal to the dividend, with `done` 2 cycles after acceptance; `irq_req` is ignored throughout.
- R12: `done` and `irq_ack` are one-cycle pulses, never high together, and never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Descriptor offered |
| op_ready | output | 1 | Sequencer idle, descriptor can be taken |
| op_kind | input | 3 | Operation code |
| op_list | input | 16 | Register list for block transfers |
| op_base | input | 32 | Base byte address |
| op_resume | input | 4 | Continuation index from the stacked status word, 0 for none |
| op_dest | input | 4 | First destination/source register for paired and divide operations |
| op_dividend | input | 32 | Divide numerator |
| op_divisor | input | 32 | Divide denominator |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory beat completes this cycle |
| mem_write | output | 1 | Beat is a store |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid in the completing cycle |
| rf_rd_idx | output | 4 | Register-file read index for store data |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| irq_req | input | 1 | Interrupt request |
| irq_ack | output | 1 | Interrupt accepted, operation stopped |
| cont_idx | output | 4 | Continuation index to stack, valid with `irq_ack` |
| done | output | 1 | Operation completed |

## Verification
The hardest case is an interrupt that lands exactly on a beat boundary while the memory is applying back-pressure. The request has to stay pending through the stalled beat and be taken only when that beat completes. The bench gates `irq_req` on its own count of completed beats, and it can also make `mem_ready` toggle every cycle, so the request is raised during a chosen beat and held through its stall. A pause followed by a reissue with the reported index shows that resumption is seamless. For the divide, the request is timed by the cycle count since acceptance, so it lands in the middle of the iterations.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    K_BLK_LD = 3'd0,
    K_BLK_ST = 3'd1,
    K_DW_LD  = 3'd2,
    K_DW_ST  = 3'd3,
    K_DIV    = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BLK,
    S_DW0,
    S_DW1,
    S_DIV,
    S_WBQ,
    S_WBR,
    S_FIN
  } seq_state_e;

endpackage

// File: rtl/ldst_scan.sv
// Finds the lowest set list bit at or above a starting index.
module ldst_scan #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  input  logic [IDXW:0]   from,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (list[i] && ((IDXW+1)'(i) >= from)) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/ldst_popbelow.sv
// Counts set list bits strictly below a limit index.
module ldst_popbelow #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] list,
  input  logic [IDXW:0]   lim,
  output logic [IDXW:0]   cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      if (list[i] && ((IDXW+1)'(i) < lim)) cnt = cnt + (IDXW+1)'(1);
    end
  end
endmodule

// File: rtl/ldst_div.sv
// Restoring divider, one quotient bit per step.
module ldst_div #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         last
);
  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      dsr_q <= divisor;
      cnt_q <= '0;
      if (divisor == '0) begin
        quo_q <= '0;
        rem_q <= dividend;
      end else begin
        quo_q <= dividend;
        rem_q <= '0;
      end
    end else if (step) begin
      cnt_q <= cnt_q + CW'(1);
      if (!diff[W]) begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign last = (cnt_q == CW'(W - 1));

  // Partial remainder always stays below the divisor once iterating.
  assert_rem_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && dsr_q != '0) |-> (rem_q < dsr_q));
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IDXW  = $clog2(NREG),
  localparam int BYTES = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [2:0]      op_kind,
  input  logic [NREG-1:0] op_list,
  input  logic [AW-1:0]   op_base,
  input  logic [IDXW-1:0] op_resume,
  input  logic [IDXW-1:0] op_dest,
  input  logic [DW-1:0]   op_dividend,
  input  logic [DW-1:0]   op_divisor,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [IDXW-1:0] rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  input  logic            irq_req,
  output logic            irq_ack,
  output logic [IDXW-1:0] cont_idx,
  output logic            done
);
  import ldst_pkg::*;

  seq_state_e      state_q, state_d;
  op_kind_e        kind_q, kind_in;
  logic [NREG-1:0] list_q;
  logic [AW-1:0]   addr_q, addr_d;
  logic [IDXW-1:0] cur_q, cur_d, dest_q;

  logic            accept, beat, is_load, is_blk;
  logic            first_found, next_found;
  logic [IDXW-1:0] first_idx, next_idx;
  logic [IDXW:0]   skipped;
  logic            div_load, div_step, div_last;
  logic [DW-1:0]   div_quo, div_rem;

  assign kind_in = op_kind_e'(op_kind);
  assign accept  = op_valid && op_ready;
  assign beat    = mem_valid && mem_ready;
  assign is_load = (kind_q == K_BLK_LD) || (kind_q == K_DW_LD);
  assign is_blk  = (kind_q == K_BLK_LD) || (kind_q == K_BLK_ST);

  // Entry point of a (possibly resumed) block transfer.
  ldst_scan #(.NREG(NREG)) u_first (
    .list (op_list),
    .from ({1'b0, op_resume}),
    .found(first_found),
    .idx  (first_idx)
  );

  ldst_popbelow #(.NREG(NREG)) u_skip (
    .list(op_list),
    .lim ({1'b0, op_resume}),
    .cnt (skipped)
  );

  // Successor of the register currently on the bus.
  ldst_scan #(.NREG(NREG)) u_next (
    .list (list_q),
    .from ({1'b0, cur_q} + (IDXW+1)'(1)),
    .found(next_found),
    .idx  (next_idx)
  );

  assign div_load = accept && (kind_in == K_DIV);

  ldst_div #(.W(DW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (div_load),
    .step    (div_step),
    .dividend(op_dividend),
    .divisor (op_divisor),
    .quo     (div_quo),
    .rem     (div_rem),
    .last    (div_last)
  );

  assign op_ready  = (state_q == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_write = !is_load;
  assign rf_rd_idx = cur_q;
  assign mem_wdata = rf_rd_data;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    cur_d     = cur_q;
    mem_valid = 1'b0;
    rf_we     = 1'b0;
    rf_waddr  = cur_q;
    rf_wdata  = mem_rdata;
    irq_ack   = 1'b0;
    cont_idx  = '0;
    done      = 1'b0;
    div_step  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          unique case (kind_in)
            K_BLK_LD, K_BLK_ST: begin
              addr_d  = op_base + AW'(skipped) * AW'(BYTES);
              cur_d   = first_idx;
              state_d = first_found ? S_BLK : S_FIN;
            end
            K_DW_LD, K_DW_ST: begin
              addr_d  = op_base;
              cur_d   = op_dest;
              state_d = S_DW0;
            end
            K_DIV:   state_d = (op_divisor == '0) ? S_WBQ : S_DIV;
            default: state_d = S_FIN;
          endcase
        end
      end
      S_BLK: begin
        mem_valid = 1'b1;
        if (beat) begin
          rf_we = is_load;
          if (!next_found) begin
            done    = 1'b1;
            state_d = S_IDLE;
          end else if (irq_req) begin
            irq_ack  = 1'b1;
            cont_idx = next_idx;
            state_d  = S_IDLE;
          end else begin
            cur_d  = next_idx;
            addr_d = addr_q + AW'(BYTES);
          end
        end
      end
      S_DW0: begin
        mem_valid = 1'b1;
        if (beat) begin
          rf_we = is_load;
          if (irq_req) begin
            irq_ack = 1'b1;
            state_d = S_IDLE;
          end else begin
            cur_d   = cur_q + IDXW'(1);
            addr_d  = addr_q + AW'(BYTES);
            state_d = S_DW1;
          end
        end
      end
      S_DW1: begin
        mem_valid = 1'b1;
        if (beat) begin
          rf_we   = is_load;
          done    = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_DIV: begin
        if (irq_req) begin
          irq_ack = 1'b1;
          state_d = S_IDLE;
        end else begin
          div_step = 1'b1;
          if (div_last) state_d = S_WBQ;
        end
      end
      S_WBQ: begin
        rf_we    = 1'b1;
        rf_waddr = dest_q;
        rf_wdata = div_quo;
        state_d  = S_WBR;
      end
      S_WBR: begin
        rf_we    = 1'b1;
        rf_waddr = dest_q + IDXW'(1);
        rf_wdata = div_rem;
        done     = 1'b1;
        state_d  = S_IDLE;
      end
      S_FIN: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_BLK_LD;
      list_q  <= '0;
      addr_q  <= '0;
      cur_q   <= '0;
      dest_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cur_q   <= cur_d;
      if (accept) begin
        kind_q <= kind_in;
        list_q <= op_list;
        dest_q <= op_dest;
      end
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !op_ready);

  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_ack && op_ready));

  assert_cont_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && is_blk) |-> (cont_idx != '0));

  assert_cancel_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !is_blk) |-> (cont_idx == '0));

  assert_div_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DIV) |-> !rf_we);

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && done));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/ldst_seq_bench.sv
module ldst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = '0;
  logic [15:0] op_list = '0;
  logic [31:0] op_base = '0;
  logic [3:0]  op_resume = '0;
  logic [3:0]  op_dest = '0;
  logic [31:0] op_dividend = '0;
  logic [31:0] op_divisor = '0;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx, rf_waddr, cont_idx;
  logic [31:0] rf_rd_data, rf_wdata;
  logic        rf_we, irq_req, irq_ack, done;

  always #5 clk = ~clk;

  // Bench-controlled stimulus knobs
  logic [3:0] irqb = '0;
  logic [7:0] irqc = '0;
  logic       stall = 1'b0;
  logic       hold = 1'b0;

  // Monitor state
  logic        running = 1'b0;
  logic        tog = 1'b0;
  int          cyc = 0, nbeats = 0, nrf = 0, nack = 0, ndone = 0;
  int          done_cyc = 0, ready_viol = 0, stray = 0;
  logic [3:0]  ack_cont = '0;
  logic [31:0] b_addr [32];
  logic        b_we   [32];
  logic [31:0] b_wd   [32];
  logic [3:0]  r_addr [32];
  logic [31:0] r_data [32];

  int nchk = 0, nfail = 0;

  assign mem_ready  = !stall || tog;
  assign mem_rdata  = mem_addr ^ 32'h5A5A_0000;
  assign rf_rd_data = 32'hC0DE_0000 | {28'd0, rf_rd_idx};
  assign irq_req    = hold ||
                      (running && irqb != 0 && nbeats == int'(irqb) - 1) ||
                      (running && irqc != 0 && cyc == int'(irqc));

  ldst_seq u_ldst_seq (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_list(op_list),
    .op_base(op_base), .op_resume(op_resume), .op_dest(op_dest),
    .op_dividend(op_dividend), .op_divisor(op_divisor),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .cont_idx(cont_idx), .done(done)
  );

  always @(posedge clk) begin
    tog <= ~tog;
    if (!rst_n) begin
      running <= 1'b0;
    end else if (op_valid && op_ready) begin
      running <= 1'b1; cyc <= 1; nbeats <= 0; nrf <= 0; nack <= 0; ndone <= 0;
      ack_cont <= '0; done_cyc <= 0;
    end else if (running) begin
      cyc <= cyc + 1;
      if (op_ready) ready_viol <= ready_viol + 1;
      if (mem_valid && mem_ready) begin
        b_addr[nbeats & 31] <= mem_addr;
        b_we[nbeats & 31]   <= mem_write;
        b_wd[nbeats & 31]   <= mem_wdata;
        nbeats <= nbeats + 1;
      end
      if (rf_we) begin
        r_addr[nrf & 31] <= rf_waddr;
        r_data[nrf & 31] <= rf_wdata;
        nrf <= nrf + 1;
      end
      if (irq_ack) begin nack <= nack + 1; ack_cont <= cont_idx; running <= 1'b0; end
      if (done) begin ndone <= ndone + 1; done_cyc <= cyc; running <= 1'b0; end
    end else if (done || irq_ack) begin
      stray <= stray + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] k, input logic [15:0] l, input logic [31:0] b,
                        input logic [3:0] r, input logic [3:0] d, input logic [31:0] dd,
                        input logic [31:0] dv, input logic [3:0] ib, input logic [7:0] ic,
                        input logic st, input logic ih);
    @(negedge clk);
    op_kind = k; op_list = l; op_base = b; op_resume = r; op_dest = d;
    op_dividend = dd; op_divisor = dv; irqb = ib; irqc = ic; stall = st; hold = ih;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    for (int t = 0; t < 300; t++) begin
      if (!running) break;
      @(negedge clk);
    end
    chk(!running, "operation timeout", {31'd0, running}, 32'd0);
    hold = 1'b0; irqb = '0; irqc = '0; stall = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] list;
    logic [31:0] base;
    logic [3:0]  res;
    logic [3:0]  dest;
    logic [3:0]  irqb;
    logic        stall;
    logic [4:0]  nb;
    logic        ack;
    logic [3:0]  cont;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h00A5, 32'h1000, 4'd0,  4'd0,  4'd0, 1'b0, 5'd4, 1'b0, 4'd0}, // R2 plain load
    '{3'd1, 16'hF00F, 32'h2000, 4'd0,  4'd0,  4'd0, 1'b1, 5'd8, 1'b0, 4'd0}, // R2 R3 stalled store
    '{3'd0, 16'h00A5, 32'h1000, 4'd0,  4'd0,  4'd2, 1'b0, 5'd2, 1'b1, 4'd5}, // R4 pause
    '{3'd0, 16'h00A5, 32'h1000, 4'd5,  4'd0,  4'd0, 1'b0, 5'd2, 1'b0, 4'd0}, // R5 resume
    '{3'd1, 16'h8001, 32'h4000, 4'd0,  4'd0,  4'd2, 1'b0, 5'd2, 1'b0, 4'd0}, // R6 last beat
    '{3'd1, 16'hFFFF, 32'h5000, 4'd15, 4'd0,  4'd0, 1'b0, 5'd1, 1'b0, 4'd0}, // R5 top register
    '{3'd2, 16'h0000, 32'h3000, 4'd0,  4'd4,  4'd0, 1'b0, 5'd2, 1'b0, 4'd0}, // R7 paired load
    '{3'd3, 16'h0000, 32'h3010, 4'd0,  4'd15, 4'd0, 1'b0, 5'd2, 1'b0, 4'd0}, // R7 wrap
    '{3'd2, 16'h0000, 32'h3020, 4'd0,  4'd2,  4'd1, 1'b1, 5'd1, 1'b1, 4'd0}, // R8 cancel
    '{3'd2, 16'h0000, 32'h3020, 4'd0,  4'd2,  4'd0, 1'b0, 5'd2, 1'b0, 4'd0}, // R8 reissue
    '{3'd0, 16'h0000, 32'h6000, 4'd0,  4'd0,  4'd0, 1'b0, 5'd0, 1'b0, 4'd0}, // R2 empty
    '{3'd0, 16'hFFFF, 32'h7000, 4'd0,  4'd0,  4'd1, 1'b1, 5'd1, 1'b1, 4'd1}  // R3 R4 stall+irq
  };
  localparam string REQ [NV] = '{"R2", "R3", "R4", "R5", "R6", "R5",
                                 "R7", "R7", "R8", "R8", "R2", "R4"};

  function automatic int exp_reg(vec_t v, int j);
    int n;
    n = 0;
    if (v.kind == 3'd2 || v.kind == 3'd3) return (int'(v.dest) + j) % 16;
    for (int i = int'(v.res); i < 16; i++) begin
      if (v.list[i]) begin
        if (n == j) return i;
        n++;
      end
    end
    return -1;
  endfunction

  function automatic int exp_off(vec_t v, int j);
    int n;
    n = 0;
    if (v.kind == 3'd2 || v.kind == 3'd3) return j;
    for (int i = 0; i < int'(v.res); i++) if (v.list[i]) n++;
    return n + j;
  endfunction

  initial begin : watchdog
    for (int t = 0; t < 150000; t++) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] ea;
    int er;
    bit ld;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(op_ready == 1'b1, "R1 reset op_ready", {31'd0, op_ready}, 32'd1);
    chk({mem_valid, rf_we, irq_ack, done} == 4'b0, "R1 reset outputs idle",
        {28'd0, mem_valid, rf_we, irq_ack, done}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run_op(v.kind, v.list, v.base, v.res, v.dest, 32'd0, 32'd0, v.irqb, 8'd0, v.stall, 1'b0);
      ld = (v.kind == 3'd0 || v.kind == 3'd2);
      chk(nbeats == int'(v.nb), $sformatf("%s vec%0d beat count", REQ[i], i), nbeats, {27'd0, v.nb});
      chk(nack == int'(v.ack), $sformatf("%s vec%0d ack count", REQ[i], i), nack, {31'd0, v.ack});
      chk(ndone == int'(!v.ack), $sformatf("%s vec%0d done count", REQ[i], i), ndone, {31'd0, !v.ack});
      if (v.ack)
        chk(ack_cont == v.cont, $sformatf("%s vec%0d continuation", REQ[i], i), {28'd0, ack_cont}, {28'd0, v.cont});
      chk(nrf == (ld ? int'(v.nb) : 0), $sformatf("%s vec%0d write count", REQ[i], i), nrf, ld ? {27'd0, v.nb} : 32'd0);
      for (int j = 0; j < int'(v.nb) && j < nbeats; j++) begin
        er = exp_reg(v, j);
        ea = v.base + 32'(4 * exp_off(v, j));
        chk(b_addr[j] == ea, $sformatf("%s vec%0d beat%0d addr", REQ[i], i, j), b_addr[j], ea);
        chk(b_we[j] == !ld, $sformatf("%s vec%0d beat%0d dir", REQ[i], i, j), {31'd0, b_we[j]}, {31'd0, !ld});
        if (!ld)
          chk(b_wd[j] == (32'hC0DE_0000 | 32'(er)), $sformatf("%s vec%0d beat%0d wdata", REQ[i], i, j),
              b_wd[j], 32'hC0DE_0000 | 32'(er));
        else begin
          chk(int'(r_addr[j]) == er, $sformatf("%s vec%0d beat%0d reg", REQ[i], i, j), {28'd0, r_addr[j]}, 32'(er));
          chk(r_data[j] == (ea ^ 32'h5A5A_0000), $sformatf("%s vec%0d beat%0d rdata", REQ[i], i, j),
              r_data[j], ea ^ 32'h5A5A_0000);
        end
      end
    end

    // R9 divide 100 / 7
    run_op(3'd4, 16'd0, 32'd0, 4'd0, 4'd6, 32'd100, 32'd7, 4'd0, 8'd0, 1'b0, 1'b0);
    chk(nrf == 2 && r_addr[0] == 4'd6 && r_data[0] == 32'd14, "R9 quotient", r_data[0], 32'd14);
    chk(r_addr[1] == 4'd7 && r_data[1] == 32'd2, "R9 remainder", r_data[1], 32'd2);
    chk(done_cyc == 34, "R9 latency", done_cyc, 32'd34);

    // R9 large operands
    run_op(3'd4, 16'd0, 32'd0, 4'd0, 4'd15, 32'hFFFF_FFFF, 32'd3, 4'd0, 8'd0, 1'b0, 1'b0);
    chk(r_data[0] == 32'h5555_5555 && r_addr[0] == 4'd15, "R9 quotient max", r_data[0], 32'h5555_5555);
    chk(r_data[1] == 32'd0 && r_addr[1] == 4'd0, "R9 remainder wrap reg", {28'd0, r_addr[1]}, 32'd0);

    // R10 interrupt in mid-divide, then reissue
    run_op(3'd4, 16'd0, 32'd0, 4'd0, 4'd3, 32'd1000, 32'd9, 4'd0, 8'd10, 1'b0, 1'b0);
    chk(nack == 1 && ndone == 0, "R10 divide cancelled", nack, 32'd1);
    chk(nrf == 0, "R10 no partial write", nrf, 32'd0);
    chk(ack_cont == 4'd0, "R10 continuation zero", {28'd0, ack_cont}, 32'd0);
    run_op(3'd4, 16'd0, 32'd0, 4'd0, 4'd3, 32'd1000, 32'd9, 4'd0, 8'd0, 1'b0, 1'b0);
    chk(nrf == 2 && r_data[0] == 32'd111 && r_data[1] == 32'd1, "R10 reissue result", r_data[0], 32'd111);

    // R11 divide by zero with interrupt held
    run_op(3'd4, 16'd0, 32'd0, 4'd0, 4'd9, 32'h0000_1234, 32'd0, 4'd0, 8'd0, 1'b0, 1'b1);
    chk(nack == 0 && ndone == 1, "R11 not interrupted", nack, 32'd0);
    chk(r_data[0] == 32'd0 && r_addr[0] == 4'd9, "R11 zero quotient", r_data[0], 32'd0);
    chk(r_data[1] == 32'h1234 && r_addr[1] == 4'd10, "R11 remainder is dividend", r_data[1], 32'h1234);
    chk(done_cyc == 2, "R11 latency", done_cyc, 32'd2);

    // R1 busy and R12 pulse hygiene over the whole run
    chk(ready_viol == 0, "R1 op_ready low while busy", ready_viol, 32'd0);
    chk(stray == 0, "R12 no pulse while idle", stray, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule